// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block collects a set of external interrupt lines (24 by default) and turns each activation into a delivery message. Every line owns a 64-bit redirection entry, kept as two 32-bit halves. The entry holds the vector, the destination, a delivery mode, the trigger mode (edge or level), the polarity (active high or active low) and a mask bit. When an unmasked line becomes active, the block sends a message on a valid/ready output port. The message carries the line's vector, destination and delivery mode, so the receiver needs no acknowledge cycle to learn which source fired.

Software sees four direct addresses. It writes an 8-bit index to address 0x00 and then reads or writes the selected internal register through the 32-bit window at 0x10. Writing a line number to 0x20 raises a software edge on that line. Writing a vector to 0x40 signals end of interrupt (EOI), which re-arms the level-triggered sources programmed with that vector.

Delivery runs through a two-state machine. In `DLV_IDLE` the machine waits. When any line requests, the transition *grant* latches the lowest-numbered requesting line and its payload and moves to `DLV_OFFER`. In `DLV_OFFER` the machine holds `msg_valid` high with a frozen payload. The transition *accept* fires when `msg_ready` is high, sends the line back to its own logic as accepted, and returns to `DLV_IDLE`. Without ready the machine stays in `DLV_OFFER` (transition *hold*).

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the index register reads 0 and `msg_valid` is low. Every entry low word reads 0x00010000 (masked, edge, active high, vector 0) and every high word reads 0.
- R2: Entry n is reached at index 0x10+2n (low word) and 0x10+2n+1 (high word). The writable low-word fields are vector [7:0], delivery mode [10:8], destination mode [11], polarity [13] (1 = active low), trigger [15] (1 = level) and mask [16]. The high word holds the destination in [31:24]. All other bits read 0.
- R3: Index 0x01 is read-only and reads version 0x20 in [7:0], 1 in [15] and the entry count minus one in [23:16] (0x00178020 by default). Index 0x00 holds a 4-bit ID in [27:24]. Index 0x02 is read-only and returns that same ID field. Index 0x03 holds one writable bit in [0].
- R4: Indices with no register behind them (0x04 to 0x0F, and 0x10+2·entries and above) read 0, and writes to them change nothing. Direct addresses other than 0x00 and 0x10 read 0.
- R5: An unmasked edge entry latches one request per active transition (rising edge, or falling edge when active low). Its message becomes valid after the second rising clock edge that follows the input change. Holding the input active sends nothing more. Transitions that occur while the entry is masked are dropped.
- R6: An unmasked level entry whose input is active and whose remote IRR (low bit 14) is clear offers a message. Acceptance sets remote IRR, and no further message follows while it stays set.
- R7: Writing a value to 0x40 clears remote IRR on every level entry whose vector equals that value. A non-matching value changes nothing.
- R8: When several lines request at once, the lowest-numbered line is delivered first, and the next line follows once the first is accepted.
- R9: While `msg_valid` is high and `msg_ready` low, `msg_valid`, `msg_vector`, `msg_dest` and `msg_mode` stay unchanged, even if the entry is reprogrammed in the meantime.
- R10: Low-word bit 12 (delivery status, read-only) reads 1 while the entry has an undelivered request and 0 otherwise.
- R11: Writing line number n to 0x20 raises a request on edge entry n if it is unmasked. The write has no effect on a level entry or on a number outside the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Direct bus address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational during `bus_rd` |
| irq_in | input | NUM_LINES | External interrupt lines |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Vector of the offered message |
| msg_dest | output | 8 | Destination of the offered message |
| msg_mode | output | 3 | Delivery mode of the offered message |

## Verification
A bus write takes effect at the rising edge inside the write cycle. Bus reads are combinational and are sampled in the same cycle. An input transition on an edge entry, or a pin-assertion write, shows as `msg_valid` one cycle after the edge that latches the request, which is two rising edges after the input change. An unmask, or an EOI on an active level entry, shows one cycle after the write's edge. After an accept, the next pending line appears one cycle after the accept edge. The directed tasks drive at falling edges and check `msg_valid` both at the cycle before it is due and at the cycle it is due. Every "nothing happens" case is observed over several cycles.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam logic [7:0] ADDR_INDEX  = 8'h00;
    localparam logic [7:0] ADDR_WINDOW = 8'h10;
    localparam logic [7:0] ADDR_PIN    = 8'h20;
    localparam logic [7:0] ADDR_EOI    = 8'h40;

    localparam logic [7:0] IDX_ID      = 8'h00;
    localparam logic [7:0] IDX_VERSION = 8'h01;
    localparam logic [7:0] IDX_ARB     = 8'h02;
    localparam logic [7:0] IDX_BOOT    = 8'h03;
    localparam logic [7:0] IDX_TABLE   = 8'h10;

    typedef enum logic [0:0] {
        DLV_IDLE  = 1'b0,
        DLV_OFFER = 1'b1
    } dlv_state_t;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       dstmode;
        logic       pol;
        logic       level;
        logic       mask;
        logic [7:0] dest;
    } entry_cfg_t;

    localparam entry_cfg_t CFG_RESET = '{
        vector:  8'h00,
        dmode:   3'd0,
        dstmode: 1'b0,
        pol:     1'b0,
        level:   1'b0,
        mask:    1'b1,
        dest:    8'h00
    };

endpackage

// File: rtl/irq_line_state.sv
module irq_line_state (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic pol,
    input  logic level,
    input  logic mask,
    input  logic accept,
    input  logic eoi_hit,
    input  logic pin_hit,
    output logic request,
    output logic remote_irr
);

    logic active;
    logic prev_q;
    logic pending_q;
    logic irr_q;
    logic edge_set;

    assign active   = raw_in ^ pol;
    assign edge_set = !level && !mask && ((active && !prev_q) || pin_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= 1'b0;
            pending_q <= 1'b0;
            irr_q     <= 1'b0;
        end else begin
            prev_q <= active;
            if (level)
                pending_q <= 1'b0;
            else if (edge_set)
                pending_q <= 1'b1;
            else if (accept)
                pending_q <= 1'b0;
            if (accept && level)
                irr_q <= 1'b1;
            else if (eoi_hit)
                irr_q <= 1'b0;
        end
    end

    always_comb begin
        if (level)
            request = active && !irr_q && !mask;
        else
            request = pending_q && !mask;
    end

    assign remote_irr = irr_q;

    AST_LEVEL_ACCEPT_SETS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
        accept && level |=> remote_irr); // R6
    AST_EOI_CLEARS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_hit && !accept |=> !remote_irr); // R7
    AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !level && !edge_set |=> !pending_q); // R5

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                idx = IDX_W'(i);
        end
    end

    assign any = |req;

    logic [N-1:0] below_mask;
    assign below_mask = (N'(1) << idx) - N'(1);

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx] && ((req & below_mask) == '0))); // R8

endmodule

// File: rtl/irq_deliver.sv
module irq_deliver
    import irq_route_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_any,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [7:0]       req_vector,
    input  logic [7:0]       req_dest,
    input  logic [2:0]       req_mode,
    input  logic             msg_ready,
    output logic             msg_valid,
    output logic [7:0]       msg_vector,
    output logic [7:0]       msg_dest,
    output logic [2:0]       msg_mode,
    output logic             accept_valid,
    output logic [IDX_W-1:0] accept_idx
);

    dlv_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       vec_q, dest_q;
    logic [2:0]       mode_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLV_IDLE:  if (req_any)   state_d = DLV_OFFER;  // grant
            DLV_OFFER: if (msg_ready) state_d = DLV_IDLE;   // accept, else hold
            default:                  state_d = DLV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DLV_IDLE;
            idx_q   <= '0;
            vec_q   <= '0;
            dest_q  <= '0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == DLV_IDLE && req_any) begin
                idx_q  <= req_idx;
                vec_q  <= req_vector;
                dest_q <= req_dest;
                mode_q <= req_mode;
            end
        end
    end

    always_comb begin
        msg_valid    = 1'b0;
        accept_valid = 1'b0;
        unique case (state_q)
            DLV_IDLE:  ;
            DLV_OFFER: begin
                msg_valid    = 1'b1;
                accept_valid = msg_ready;
            end
            default:   ;
        endcase
        msg_vector = vec_q;
        msg_dest   = dest_q;
        msg_mode   = mode_q;
        accept_idx = idx_q;
    end

    AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)
                                    && $stable(msg_dest) && $stable(msg_mode)); // R9

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int         NUM_LINES   = 24,
    parameter logic [7:0] VERSION_NUM = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [7:0]           msg_vector,
    output logic [7:0]           msg_dest,
    output logic [2:0]           msg_mode
);

    localparam int         IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int         TABLE_END = 16 + 2 * NUM_LINES;
    localparam logic [7:0] TOP_ENTRY = 8'(NUM_LINES - 1);

    logic [7:0]  index_q;
    logic [3:0]  ctl_id_q;
    logic        boot_q;
    entry_cfg_t  cfg_q [NUM_LINES];

    logic wr_index, wr_window, wr_pin, wr_eoi;
    logic in_table, sel_high;
    logic [IDX_W-1:0] sel_entry;
    logic [7:0] table_off;

    logic [NUM_LINES-1:0] req_vec, irr_vec;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic             accept_valid;
    logic [IDX_W-1:0] accept_idx;
    logic [31:0]      window_rd;

    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

    assign wr_index  = bus_wr && (bus_addr == ADDR_INDEX);
    assign wr_window = bus_wr && (bus_addr == ADDR_WINDOW);
    assign wr_pin    = bus_wr && (bus_addr == ADDR_PIN);
    assign wr_eoi    = bus_wr && (bus_addr == ADDR_EOI);

    assign in_table  = (index_q >= IDX_TABLE) && (32'(index_q) < TABLE_END);
    assign table_off = (index_q - IDX_TABLE) >> 1;
    assign sel_entry = IDX_W'(table_off);
    assign sel_high  = index_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q  <= '0;
            ctl_id_q <= '0;
            boot_q   <= 1'b0;
            for (int i = 0; i < NUM_LINES; i++)
                cfg_q[i] <= CFG_RESET;
        end else begin
            if (wr_index)
                index_q <= bus_wdata[7:0];
            if (wr_window) begin
                if (index_q == IDX_ID)
                    ctl_id_q <= bus_wdata[27:24];
                else if (index_q == IDX_BOOT)
                    boot_q <= bus_wdata[0];
                else if (in_table) begin
                    if (sel_high)
                        cfg_q[sel_entry].dest <= bus_wdata[31:24];
                    else begin
                        cfg_q[sel_entry].vector  <= bus_wdata[7:0];
                        cfg_q[sel_entry].dmode   <= bus_wdata[10:8];
                        cfg_q[sel_entry].dstmode <= bus_wdata[11];
                        cfg_q[sel_entry].pol     <= bus_wdata[13];
                        cfg_q[sel_entry].level   <= bus_wdata[15];
                        cfg_q[sel_entry].mask    <= bus_wdata[16];
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_state u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_in     (irq_in[g]),
            .pol        (cfg_q[g].pol),
            .level      (cfg_q[g].level),
            .mask       (cfg_q[g].mask),
            .accept     (accept_valid && (accept_idx == IDX_W'(g))),
            .eoi_hit    (wr_eoi && (bus_wdata[7:0] == cfg_q[g].vector)),
            .pin_hit    (wr_pin && (bus_wdata[7:0] == 8'(g))),
            .request    (req_vec[g]),
            .remote_irr (irr_vec[g])
        );
    end

    irq_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_vec),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    irq_deliver #(.IDX_W(IDX_W)) u_deliver (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_any      (pick_any),
        .req_idx      (pick_idx),
        .req_vector   (cfg_q[pick_idx].vector),
        .req_dest     (cfg_q[pick_idx].dest),
        .req_mode     (cfg_q[pick_idx].dmode),
        .msg_ready    (msg_ready),
        .msg_valid    (msg_valid),
        .msg_vector   (msg_vector),
        .msg_dest     (msg_dest),
        .msg_mode     (msg_mode),
        .accept_valid (accept_valid),
        .accept_idx   (accept_idx)
    );

    always_comb begin
        window_rd = '0;
        case (index_q)
            IDX_ID, IDX_ARB: window_rd = {4'h0, ctl_id_q, 24'h0};
            IDX_VERSION:     window_rd = {8'h00, TOP_ENTRY, 1'b1, 7'h00, VERSION_NUM};
            IDX_BOOT:        window_rd = {31'h0, boot_q};
            default: begin
                if (in_table) begin
                    if (sel_high)
                        window_rd = {cfg_q[sel_entry].dest, 24'h0};
                    else
                        window_rd = {15'h0, cfg_q[sel_entry].mask, cfg_q[sel_entry].level,
                                     irr_vec[sel_entry], cfg_q[sel_entry].pol,
                                     req_vec[sel_entry], cfg_q[sel_entry].dstmode,
                                     cfg_q[sel_entry].dmode, cfg_q[sel_entry].vector};
                end
            end
        endcase
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_INDEX)
                bus_rdata = {24'h0, index_q};
            else if (bus_addr == ADDR_WINDOW)
                bus_rdata = window_rd;
        end
    end

    AST_MSG_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && !pick_any |=> !msg_valid); // R8

endmodule

// File: tb/irq_route_ctrl_bench.sv
`timescale 1ns/1ps
module irq_route_ctrl_bench;

    localparam int NL = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq_in = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [7:0]    msg_vector, msg_dest;
    logic [2:0]    msg_mode;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_route_ctrl #(.NUM_LINES(NL)) u_irq_route_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_mode(msg_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic ind_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_write(8'h10, d);
    endtask

    task automatic ind_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_read(8'h10, d);
    endtask

    task automatic accept_msg(input string req);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        chk(req, {31'h0, msg_valid}, 32'd0);
    endtask

    task automatic quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, {31'h0, msg_valid}, 32'd0);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 valid after reset", {31'h0, msg_valid}, 32'd0);
        bus_read(8'h00, d);
        chk("R1 index reset", d, 32'h0);
        ind_read(8'h10, d);
        chk("R1 entry0 low", d, 32'h0001_0000);
        ind_read(8'h10 + 8'd47, d);
        chk("R1 entry23 high", d, 32'h0);
        ind_read(8'h10 + 8'd20, d);
        chk("R1 entry10 low", d, 32'h0001_0000);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        ind_write(8'h1A, 32'hFFFF_FFFF);
        ind_read(8'h1A, d);
        chk("R2 entry5 low fields", d, 32'h0001_AFFF);
        ind_write(8'h1A, 32'h0001_0000);
        ind_write(8'h1B, 32'hFFFF_FFFF);
        ind_read(8'h1B, d);
        chk("R2 entry5 high dest", d, 32'hFF00_0000);
        ind_read(8'h01, d);
        chk("R3 version", d, 32'h0017_8020);
        ind_write(8'h01, 32'h0);
        ind_read(8'h01, d);
        chk("R3 version read-only", d, 32'h0017_8020);
        ind_write(8'h00, 32'hFFFF_FFFF);
        ind_read(8'h00, d);
        chk("R3 id field", d, 32'h0F00_0000);
        ind_write(8'h02, 32'h0);
        ind_read(8'h02, d);
        chk("R3 arbitration mirrors id", d, 32'h0F00_0000);
        ind_write(8'h03, 32'hFFFF_FFFF);
        ind_read(8'h03, d);
        chk("R3 boot bit", d, 32'h1);
        ind_write(8'h04, 32'hFFFF_FFFF);
        ind_read(8'h04, d);
        chk("R4 hole 0x04", d, 32'h0);
        ind_write(8'h40, 32'hFFFF_FFFF);
        ind_read(8'h40, d);
        chk("R4 past table 0x40", d, 32'h0);
        ind_read(8'h3F, d);
        chk("R4 last high untouched", d, 32'h0);
        bus_read(8'h20, d);
        chk("R4 direct 0x20 reads zero", d, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        ind_write(8'h17, 32'h0A00_0000);
        ind_write(8'h16, 32'h0000_0333);
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk);
        chk("R5 edge not yet valid", {31'h0, msg_valid}, 32'd0);
        @(negedge clk);
        chk("R5 edge valid", {31'h0, msg_valid}, 32'd1);
        chk("R5 vector", {24'h0, msg_vector}, 32'h33);
        chk("R5 dest", {24'h0, msg_dest}, 32'h0A);
        chk("R5 mode", {29'h0, msg_mode}, 32'd3);
        ind_read(8'h16, d);
        chk("R10 status while offered", d, 32'h0000_1333);
        accept_msg("R5 accept drops valid");
        ind_read(8'h16, d);
        chk("R10 status after accept", d, 32'h0000_0333);
        quiet("R5 held input sends once", 4);
        irq_in[3] = 1'b0;
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R5 second transition", {31'h0, msg_valid}, 32'd1);
        accept_msg("R5 second accept");
        ind_write(8'h16, 32'h0001_0333);
        irq_in[3] = 1'b0;
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk);
        ind_write(8'h16, 32'h0000_0333);
        quiet("R5 masked edge dropped", 4);
        irq_in[4] = 1'b1;
        ind_write(8'h18, 32'h0000_2044);
        quiet("R5 active-low idle", 3);
        irq_in[4] = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R5 falling edge active low", {24'h0, msg_vector, 7'h0, msg_valid}, {24'h0, 8'h44, 7'h0, 1'b1});
        accept_msg("R5 active-low accept");
    endtask

    task automatic t_level();
        logic [31:0] d;
        irq_in[7] = 1'b1;
        ind_write(8'h1F, 32'h0700_0000);
        ind_write(8'h1E, 32'h0000_8077);
        chk("R6 level not yet valid", {31'h0, msg_valid}, 32'd0);
        @(negedge clk);
        chk("R6 level valid", {24'h0, msg_vector, 7'h0, msg_valid}, {24'h0, 8'h77, 7'h0, 1'b1});
        accept_msg("R6 level accept");
        ind_read(8'h1E, d);
        chk("R6 remote IRR set", d, 32'h0000_C077);
        quiet("R6 no repeat while IRR", 4);
        bus_write(8'h40, 32'h78);
        quiet("R7 wrong vector EOI ignored", 3);
        ind_read(8'h1E, d);
        chk("R7 IRR kept", d, 32'h0000_C077);
        bus_write(8'h40, 32'h77);
        chk("R7 EOI not yet valid", {31'h0, msg_valid}, 32'd0);
        @(negedge clk);
        chk("R7 EOI re-arms", {31'h0, msg_valid}, 32'd1);
        accept_msg("R7 accept after EOI");
        irq_in[7] = 1'b0;
        bus_write(8'h40, 32'h77);
        quiet("R6 inactive level silent", 3);
        ind_read(8'h1E, d);
        chk("R7 IRR cleared", d, 32'h0000_8077);
    endtask

    task automatic t_priority();
        ind_write(8'h22, 32'h0000_0099);
        ind_write(8'h28, 32'h0000_00C0);
        @(negedge clk); irq_in[12] = 1'b1; irq_in[9] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R8 lowest line first", {24'h0, msg_vector}, 32'h99);
        ind_write(8'h22, 32'h0000_005A);
        chk("R9 vector held", {24'h0, msg_vector}, 32'h99);
        chk("R9 valid held", {31'h0, msg_valid}, 32'd1);
        accept_msg("R8 first accept");
        @(negedge clk);
        chk("R8 next line follows", {24'h0, msg_vector, 7'h0, msg_valid}, {24'h0, 8'hC0, 7'h0, 1'b1});
        accept_msg("R8 second accept");
    endtask

    task automatic t_pin();
        ind_write(8'h2E, 32'h0000_00F1);
        bus_write(8'h20, 32'd15);
        chk("R11 pin not yet valid", {31'h0, msg_valid}, 32'd0);
        @(negedge clk);
        chk("R11 pin assert", {24'h0, msg_vector, 7'h0, msg_valid}, {24'h0, 8'hF1, 7'h0, 1'b1});
        accept_msg("R11 pin accept");
        bus_write(8'h20, 32'd7);
        quiet("R11 level entry ignores pin", 3);
        bus_write(8'h20, 32'd30);
        quiet("R11 out-of-range ignored", 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_edge();
        t_level();
        t_priority();
        t_pin();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule